// File: doc/BRIEF.md
# Descriptor Dispatcher with Control/Status Bank

This block is the front end of a scatter-gather DMA engine. A host builds a transfer descriptor of eight 32-bit words in a staging area and then writes the last word, the descriptor control word. If bit 31 (go) of that word is set, the block copies the whole descriptor into a descriptor FIFO as one entry. The block then hands descriptors one at a time to a data mover over a valid/ready stream. It keeps a small record of each issued descriptor's interrupt settings, so it can match the mover's completion responses to the descriptors that produced them.

Responses from the mover go into a response FIFO. The host reads each response back as two words, and reading the status word pops the entry. A control register holds the stop controls, the stop-on-error and stop-on-early-termination controls, and a global interrupt enable. The status register shows live FIFO state and three latched event bits, which the host clears by writing one to them. A soft reset runs for a fixed number of cycles. While it runs, the resetting flag is set, and the host polls that flag to see when the reset is done.

The register bus uses word addresses:
- 0: status
- 1: control
- 2: descriptor fill level
- 3: response fill level
- 4: response byte count
- 5: response status
- 8 to 15: descriptor words 0 to 7 (write-only)

Descriptor word k appears on `dsc_data[32*k+31:32*k]`.

Top module: `dd_dispatch`

## Requirements
- R1: A write to address 15 with bit 31 set enqueues one entry made of staged words 0-6 (written at addresses 8-14) plus the written control word. A write to address 15 with bit 31 clear enqueues nothing. Entries leave on `dsc_data` in commit order, with word k at bits 32k+31:32k.
- R2: The register at address 2 returns the descriptor FIFO count in both bits 31:16 and bits 15:0. A go write while the FIFO holds DESC_DEPTH entries is dropped.
- R3: The status register (address 0) has these live bits: bit 0 busy (FIFO non-empty or a descriptor awaiting its response), bit 1 descriptor FIFO empty, bit 2 descriptor FIFO full, bit 3 response FIFO empty, bit 4 response FIFO full. After reset the status register reads 0x00A.
- R4: While control bit 0 (stop) or bit 5 (stop descriptors) is set, `dsc_valid` stays low, the host can still enqueue descriptors, and status bit 5 (stopped) reads one.
- R5: A response accepted on the response stream is stored in the response FIFO. Its count appears in bits 15:0 of address 3. Address 4 returns the byte count and address 5 returns the status word, and reading address 5 pops the entry. `rsp_ready` is low while the response FIFO is full.
- R6: Status bit 9 is set when a response arrives and any of these holds for its descriptor: control bit 14 is set; control bit 15 is set and response bit 8 (early termination) is set; or control bits 23:16 AND response bits 7:0 is nonzero. `irq` equals status bit 9 AND control bit 4.
- R7: Writing address 0 clears each of status bits 7, 8 and 9 whose written bit is one, and leaves the others unchanged.
- R8: With control bit 2 set, a response whose bits 7:0 are nonzero sets status bits 7 and 5 and halts dispatch. With control bit 3 set, a response with bit 8 set sets status bits 8 and 5 and halts dispatch. Dispatch resumes once these bits are cleared.
- R9: Writing control bit 1 sets status bit 6 for RESET_CYCLES cycles, during which `dsc_valid` and `rsp_ready` are low. Afterwards both FIFOs are empty, the control register reads 0, and the status register reads 0x00A.
- R10: No more than MAX_OUT descriptors are issued without a matching response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops response on address 5) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| dsc_valid | output | 1 | Descriptor available to the mover |
| dsc_ready | input | 1 | Mover accepts descriptor |
| dsc_data | output | 256 | Eight descriptor words |
| rsp_valid | input | 1 | Mover response valid |
| rsp_ready | output | 1 | Response FIFO can accept |
| rsp_bytes | input | 32 | Bytes transferred |
| rsp_status | input | 32 | Response status (error 7:0, early 8) |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the descriptor FIFO to capacity and then issues one more go write. A design that wrapped or overwrote an entry on that write would send a corrupted or repeated descriptor to the mover, and the scoreboard would catch it. The bench also holds dispatch with the stop controls and with the outstanding limit in place. A design that ignored either would issue descriptors early, and the fill level and the issue order would both expose it.

Interrupts are tested for each trigger (completion bit, early termination, error mask) and also for a response with no matching trigger. They are tested together with the write-one-to-clear rule, so a design that cleared on a zero write, or set the flag with no cause, would show the wrong `irq` level. The soft reset is started while descriptors and responses are queued. A design that failed to flush them, or that handshook while resetting, would leave nonzero fill levels or deliver stale descriptors.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int NUM_WORDS = 8;
  localparam int DESC_W    = NUM_WORDS * 32;

  // register word addresses
  localparam logic [3:0] A_STATUS = 4'd0;
  localparam logic [3:0] A_CTL    = 4'd1;
  localparam logic [3:0] A_DFILL  = 4'd2;
  localparam logic [3:0] A_RFILL  = 4'd3;
  localparam logic [3:0] A_RBYTES = 4'd4;
  localparam logic [3:0] A_RSTAT  = 4'd5;
  localparam logic [3:0] A_DCTL   = 4'd15;

  // control register bits
  localparam int C_STOP       = 0;
  localparam int C_RESET      = 1;
  localparam int C_STOP_ERR   = 2;
  localparam int C_STOP_EARLY = 3;
  localparam int C_GIE        = 4;
  localparam int C_STOP_DESC  = 5;

  // per-descriptor interrupt record kept while the mover works on it
  typedef struct packed {
    logic       cmp;
    logic       early;
    logic [7:0] errmask;
  } tag_t;

  localparam int TAG_W = $bits(tag_t);

  function automatic tag_t tag_of(input logic [31:0] ctl_word);
    tag_t t;
    t.cmp     = ctl_word[14];
    t.early   = ctl_word[15];
    t.errmask = ctl_word[23:16];
    return t;
  endfunction

  function automatic logic raises_irq(input tag_t t, input logic [31:0] st);
    return t.cmp | (t.early & st[8]) | ((t.errmask & st[7:0]) != 8'd0);
  endfunction

  function automatic logic [31:0] dual_level(input logic [15:0] n);
    return {n, n};
  endfunction
endpackage

// File: rtl/dd_fifo.sv
module dd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign count = wp - rp;
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clr) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/dd_stage.sv
module dd_stage #(
  parameter int WORDS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [2:0]            wr_idx,
  input  logic [31:0]           wdata,
  output logic [WORDS*32-1:0]   words
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          words[g*32 +: 32] <= '0;
      else if (clr)                        words[g*32 +: 32] <= '0;
      else if (wr_en && wr_idx == 3'(g))   words[g*32 +: 32] <= wdata;
    end
  end
endmodule

// File: rtl/dd_dispatch.sv
module dd_dispatch
  import dd_pkg::*;
#(
  parameter int DESC_DEPTH   = 4,
  parameter int RESP_DEPTH   = 4,
  parameter int MAX_OUT      = 2,
  parameter int RESET_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [3:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         dsc_valid,
  input  logic         dsc_ready,
  output logic [255:0] dsc_data,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [31:0]  rsp_bytes,
  input  logic [31:0]  rsp_status,
  output logic         irq
);
  localparam int DAW = $clog2(DESC_DEPTH);
  localparam int RAW = $clog2(RESP_DEPTH);
  localparam int TAW = $clog2(MAX_OUT);
  localparam int CW  = $clog2(RESET_CYCLES + 1);

  // ---------------- state ----------------
  logic [5:0]    ctl_q;
  logic          lat_err, lat_early, irq_lat;
  logic [CW-1:0] rst_cnt;

  // ---------------- named events ----------------
  logic resetting, rst_start, wr_ctl, wr_stat, go_write, stage_wr;
  logic halt, busy, dsc_fire, rsp_fire, rd_pop;
  logic irq_event, err_event, early_event;

  logic             desc_empty, desc_full, rsp_empty, rsp_full, tag_empty, tag_full;
  logic [DAW:0]     desc_cnt;
  logic [RAW:0]     rsp_cnt;
  logic [TAW:0]     tag_cnt;
  logic [15:0]      desc_lvl, rsp_lvl, tag_lvl;
  logic [DESC_W-1:0] commit_word, desc_dout;
  logic [6*32+31:0] staged;
  logic [63:0]      rsp_dout;
  tag_t             tag_dout, cur_tag;
  logic [31:0]      clr_mask, status_w;

  assign resetting = (rst_cnt != '0);
  assign wr_ctl    = bus_wr && bus_addr == A_CTL && !resetting;
  assign wr_stat   = bus_wr && bus_addr == A_STATUS && !resetting;
  assign rst_start = wr_ctl && bus_wdata[C_RESET];
  assign go_write  = bus_wr && bus_addr == A_DCTL && bus_wdata[31] && !resetting;
  assign stage_wr  = bus_wr && bus_addr[3] && bus_addr != A_DCTL && !resetting;
  assign clr_mask  = wr_stat ? bus_wdata : 32'd0;

  assign halt      = ctl_q[C_STOP] | ctl_q[C_STOP_DESC] | lat_err | lat_early;
  assign dsc_valid = !desc_empty && !halt && !resetting && !tag_full;
  assign dsc_fire  = dsc_valid && dsc_ready;
  assign dsc_data  = desc_dout;
  assign busy      = !desc_empty || !tag_empty;

  assign rsp_ready = !rsp_full && !resetting;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign rd_pop    = bus_rd && bus_addr == A_RSTAT && !rsp_empty && !resetting;

  assign cur_tag     = tag_empty ? tag_t'('0) : tag_dout;
  assign irq_event   = rsp_fire && raises_irq(cur_tag, rsp_status);
  assign err_event   = rsp_fire && rsp_status[7:0] != 8'd0 && ctl_q[C_STOP_ERR];
  assign early_event = rsp_fire && rsp_status[8] && ctl_q[C_STOP_EARLY];

  assign irq = irq_lat & ctl_q[C_GIE];

  assign desc_lvl = 16'(desc_cnt);
  assign rsp_lvl  = 16'(rsp_cnt);
  assign tag_lvl  = 16'(tag_cnt);

  // ---------------- descriptor staging and FIFO ----------------
  dd_stage #(.WORDS(7)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr(resetting),
    .wr_en(stage_wr), .wr_idx(bus_addr[2:0]), .wdata(bus_wdata),
    .words(staged)
  );

  assign commit_word = {bus_wdata, staged};

  dd_fifo #(.W(DESC_W), .DEPTH(DESC_DEPTH)) u_desc_q (
    .clk(clk), .rst_n(rst_n), .clr(resetting),
    .push(go_write), .din(commit_word),
    .pop(dsc_fire), .dout(desc_dout),
    .empty(desc_empty), .full(desc_full), .count(desc_cnt)
  );

  // ---------------- in-flight interrupt records ----------------
  dd_fifo #(.W(TAG_W), .DEPTH(MAX_OUT)) u_tag_q (
    .clk(clk), .rst_n(rst_n), .clr(resetting),
    .push(dsc_fire), .din(tag_of(desc_dout[DESC_W-1 -: 32])),
    .pop(rsp_fire), .dout(tag_dout),
    .empty(tag_empty), .full(tag_full), .count(tag_cnt)
  );

  // ---------------- response FIFO ----------------
  dd_fifo #(.W(64), .DEPTH(RESP_DEPTH)) u_rsp_q (
    .clk(clk), .rst_n(rst_n), .clr(resetting),
    .push(rsp_fire), .din({rsp_status, rsp_bytes}),
    .pop(rd_pop), .dout(rsp_dout),
    .empty(rsp_empty), .full(rsp_full), .count(rsp_cnt)
  );

  // ---------------- control, latched status, reset sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      lat_err   <= 1'b0;
      lat_early <= 1'b0;
      irq_lat   <= 1'b0;
      rst_cnt   <= '0;
    end else if (resetting) begin
      ctl_q     <= '0;
      lat_err   <= 1'b0;
      lat_early <= 1'b0;
      irq_lat   <= 1'b0;
      rst_cnt   <= rst_cnt - 1'b1;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata[5:0] & ~6'(1 << C_RESET);
      if (rst_start) rst_cnt <= CW'(RESET_CYCLES);
      lat_err   <= err_event   | (lat_err   & ~clr_mask[7]);
      lat_early <= early_event | (lat_early & ~clr_mask[8]);
      irq_lat   <= irq_event   | (irq_lat   & ~clr_mask[9]);
    end
  end

  // ---------------- read side ----------------
  always_comb begin
    status_w     = '0;
    status_w[0]  = busy;
    status_w[1]  = desc_empty;
    status_w[2]  = desc_full;
    status_w[3]  = rsp_empty;
    status_w[4]  = rsp_full;
    status_w[5]  = halt;
    status_w[6]  = resetting;
    status_w[7]  = lat_err;
    status_w[8]  = lat_early;
    status_w[9]  = irq_lat;
  end

  always_comb begin
    case (bus_addr)
      A_STATUS: bus_rdata = status_w;
      A_CTL:    bus_rdata = {26'd0, ctl_q};
      A_DFILL:  bus_rdata = dual_level(desc_lvl);
      A_RFILL:  bus_rdata = {16'd0, rsp_lvl};
      A_RBYTES: bus_rdata = rsp_empty ? 32'd0 : rsp_dout[31:0];
      A_RSTAT:  bus_rdata = rsp_empty ? 32'd0 : rsp_dout[63:32];
      default:  bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/dd_dispatch_chk.sv
module dd_dispatch_chk #(
  parameter int MAX_OUT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dsc_valid,
  input logic        dsc_fire,
  input logic        rsp_ready,
  input logic        rsp_fire,
  input logic        halt,
  input logic        resetting,
  input logic        rst_start,
  input logic        busy,
  input logic        desc_empty,
  input logic        desc_full,
  input logic        irq_lat,
  input logic [15:0] desc_lvl,
  input logic [15:0] rsp_lvl,
  input logic [15:0] tag_lvl
);
  a_r4_halt_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !dsc_valid);

  a_r9_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> (!dsc_valid && !rsp_ready));

  a_r9_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetting) |-> (desc_lvl == 16'd0 && rsp_lvl == 16'd0));

  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_full && !dsc_fire && !resetting && !rst_start) |=> $stable(desc_lvl));

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lat) |-> $past(rsp_fire));

  a_r10_out_limit: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_fire |-> (tag_lvl < 16'(MAX_OUT)));

  a_r3_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> desc_empty);
endmodule

bind dd_dispatch dd_dispatch_chk #(.MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dsc_valid(dsc_valid), .dsc_fire(dsc_fire),
  .rsp_ready(rsp_ready), .rsp_fire(rsp_fire),
  .halt(halt), .resetting(resetting), .rst_start(rst_start),
  .busy(busy), .desc_empty(desc_empty), .desc_full(desc_full),
  .irq_lat(irq_lat),
  .desc_lvl(desc_lvl), .rsp_lvl(rsp_lvl), .tag_lvl(tag_lvl)
);

// File: tb/dd_dispatch_bench.sv
module dd_dispatch_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         dsc_valid;
  logic         dsc_ready = 1'b0;
  logic [255:0] dsc_data;
  logic         rsp_valid = 1'b0;
  logic         rsp_ready;
  logic [31:0]  rsp_bytes = '0, rsp_status = '0;
  logic         irq;

  int tests = 0;
  int fails = 0;
  logic [255:0] exp_q [$];
  logic [31:0]  rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dd_dispatch u_dd_dispatch (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_data(dsc_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_bytes(rsp_bytes), .rsp_status(rsp_status), .irq(irq)
  );

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: stage words 0-6, commit with the control word, record expectation
  task automatic push_desc(input int id, input logic [31:0] ctl, input bit expect_out);
    logic [255:0] e;
    for (int k = 0; k < 7; k++) begin
      e[k*32 +: 32] = 32'hD000_0000 | (32'(id) << 8) | 32'(k);
      wr(4'(8 + k), e[k*32 +: 32]);
    end
    e[255 -: 32] = ctl;
    wr(4'd15, ctl);
    if (expect_out) exp_q.push_back(e);
  endtask

  task automatic send_rsp(input logic [31:0] b, input logic [31:0] s);
    @(posedge clk); #1;
    rsp_valid = 1'b1; rsp_bytes = b; rsp_status = s;
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  // monitor: compare issued descriptors against the scoreboard (R1)
  always @(negedge clk) begin
    if (rst_n && dsc_valid && dsc_ready) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R1 unexpected descriptor got %h exp none", dsc_data);
      end else begin
        chk("R1 descriptor content/order", dsc_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog got timeout exp completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    rd(4'd0, rv); chk("R3 reset status", rv, 32'h00A);
    rd(4'd1, rv); chk("R9 reset control", rv, 32'h0);

    // R1: control word without go enqueues nothing
    for (int k = 0; k < 7; k++) wr(4'(8 + k), 32'h1234_0000 | 32'(k));
    wr(4'd15, 32'h0000_4000);
    rd(4'd2, rv); chk("R1 no go no entry", rv, 32'h0);

    // fill the FIFO; the fifth go is dropped (R2)
    push_desc(0, 32'h8000_4000, 1);
    push_desc(1, 32'h80FF_0000, 1);
    push_desc(2, 32'h8000_0000, 1);
    push_desc(3, 32'h8000_0000, 1);
    rd(4'd2, rv); chk("R2 fill level", rv, 32'h0004_0004);
    rd(4'd0, rv); chk("R3 busy/full status", rv, 32'h00D);
    push_desc(9, 32'h8000_0000, 0);
    rd(4'd2, rv); chk("R2 full go dropped", rv, 32'h0004_0004);

    // R4: stop holds dispatch
    wr(4'd1, 32'h01);
    dsc_ready = 1'b1;
    idle(5);
    rd(4'd2, rv); chk("R4 stop holds", rv, 32'h0004_0004);
    rd(4'd0, rv); chk("R4 stopped bit", rv & 32'h20, 32'h20);
    wr(4'd1, 32'h21);
    wr(4'd1, 32'h30);
    idle(3);
    rd(4'd2, rv); chk("R4 stop-desc holds", rv, 32'h0004_0004);

    // R10: release, only MAX_OUT issued
    wr(4'd1, 32'h10);
    idle(5);
    rd(4'd2, rv); chk("R10 outstanding limit", rv, 32'h0002_0002);

    // R5/R6: response for D0 (completion irq)
    send_rsp(32'd100, 32'h0);
    idle(3);
    chk("R6 completion irq", irq, 1'b1);
    rd(4'd2, rv); chk("R10 next issued", rv, 32'h0001_0001);
    rd(4'd3, rv); chk("R5 resp fill", rv, 32'h1);
    rd(4'd4, rv); chk("R5 resp bytes", rv, 32'd100);
    rd(4'd5, rv); chk("R5 resp status", rv, 32'h0);
    rd(4'd3, rv); chk("R5 pop on status read", rv, 32'h0);

    // R7: write-one-to-clear
    wr(4'd0, 32'h0);
    idle(1);
    chk("R7 zero write keeps irq", irq, 1'b1);
    wr(4'd0, 32'h200);
    idle(1);
    chk("R7 one clears irq", irq, 1'b0);

    // R6: error-mask match on D1, no trigger on D2
    send_rsp(32'd200, 32'h3);
    idle(2);
    chk("R6 error mask irq", irq, 1'b1);
    wr(4'd0, 32'h200);
    send_rsp(32'd300, 32'h0);
    idle(2);
    chk("R6 no trigger no irq", irq, 1'b0);

    // R8: stop on error with D3
    wr(4'd1, 32'h14);
    send_rsp(32'd400, 32'h1);
    idle(2);
    rd(4'd0, rv); chk("R8 stop on error bits", rv & 32'h3A0, 32'h0A0);
    push_desc(4, 32'h8000_8000, 1);
    idle(5);
    rd(4'd2, rv); chk("R8 halted after error", rv, 32'h0001_0001);
    wr(4'd0, 32'h80);
    idle(5);
    rd(4'd2, rv); chk("R8 resumes after clear", rv, 32'h0);

    // R8/R6: early termination on D4
    wr(4'd1, 32'h1C);
    send_rsp(32'd500, 32'h100);
    idle(2);
    rd(4'd0, rv); chk("R8 early stop bits", rv & 32'h3A0, 32'h320);
    chk("R6 early irq", irq, 1'b1);
    rd(4'd0, rv); chk("R5 resp full bit", rv & 32'h10, 32'h10);
    @(negedge clk);
    chk("R5 ready low when full", rsp_ready, 1'b0);
    wr(4'd0, 32'h3FF);
    idle(1);
    rd(4'd0, rv); chk("R7 clear all latched", rv & 32'h3A0, 32'h0);
    chk("R7 irq cleared", irq, 1'b0);

    // R9: soft reset with queued work
    dsc_ready = 1'b0;
    push_desc(5, 32'h8000_0000, 0);
    push_desc(6, 32'h8000_0000, 0);
    rd(4'd2, rv); chk("R9 queued before reset", rv, 32'h0002_0002);
    wr(4'd1, 32'h12);
    rd(4'd0, rv); chk("R9 resetting flag", rv & 32'h40, 32'h40);
    @(negedge clk);
    chk("R9 no response accept", rsp_ready, 1'b0);
    idle(8);
    rd(4'd0, rv); chk("R9 status after reset", rv, 32'h00A);
    rd(4'd1, rv); chk("R9 control after reset", rv, 32'h0);
    rd(4'd2, rv); chk("R9 desc fifo flushed", rv, 32'h0);
    rd(4'd3, rv); chk("R9 resp fifo flushed", rv, 32'h0);

    // R1: commit works again after reset
    dsc_ready = 1'b1;
    push_desc(7, 32'h8000_0000, 1);
    idle(5);
    rd(4'd2, rv); chk("R1 post-reset issue", rv, 32'h0);
    chk("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule